// File: doc/BRIEF.md
# Idle-Noise Squelch Gate

This block sits on a 16-bit signed PCM sample stream ahead of any gain or
filtering stage. It checks every valid sample against an 8-bit host-set level.
Once the signal magnitude has stayed under that level for a full hold window of
consecutive samples, the block sends zeros instead of the input. The window is
25 ms, which is 200 samples at 8 kHz. Later stages then have no low-level hiss
to amplify while the line is silent. The first sample that reaches the level
re-opens the gate at once, and that sample goes through unaltered.

The core is a three-state machine:

- `ST_PASS`: no quiet run is in progress.
- `ST_COUNT`: a quiet run is being timed.
- `ST_MUTE`: squelch is active.

These transitions are taken on a valid sample:

- **start-run** (`ST_PASS`→`ST_COUNT`): the sample is quiet.
- **extend-run** (`ST_COUNT`→`ST_COUNT`): the sample is quiet and the window is not yet complete.
- **window-complete** (`ST_PASS`/`ST_COUNT`→`ST_MUTE`): the quiet run reaches the hold count.
- **stay-muted** (`ST_MUTE`→`ST_MUTE`): the sample is quiet.
- **release** (any state→`ST_PASS`): the sample is loud, or the gate is disabled.

On a cycle with no valid sample the machine holds its state. When the enhancement
path is in bypass, `gate_en` is driven low and the stream passes untouched. The
host level register is outside this block; it should come out of reset at 0x1F.

Top module: `squelch_gate`

## Requirements
- R1: `out_valid` is high exactly one clock after `in_valid` was high. `out_sample` changes only after a valid input.
- R2: A sample is quiet when its magnitude, zero-extended to 16 bits, is strictly below `quiet_level` zero-extended to 16 bits. A magnitude equal to the level counts as loud. The magnitude of -32768 is taken as 32767.
- R3: The valid sample that completes a run of HOLD_COUNT consecutive quiet samples (default 200) is output as 0. `squelch_on` rises together with that output.
- R4: While `squelch_on` is high, every output sample is 0.
- R5: A loud sample clears the quiet run and drops `squelch_on` on that same output. That sample is passed unchanged. A run of HOLD_COUNT-1 quiet samples followed by a loud one never squelches.
- R6: Cycles with `in_valid` low neither extend nor break a quiet run. `squelch_on` does not change on them.
- R7: With `gate_en` low, samples pass unchanged, the quiet run is cleared and `squelch_on` is low.
- R8: The quiet count saturates. An unbounded quiet stretch keeps squelch active and never wraps back to pass.
- R9: After reset `out_valid`, `out_sample` and `squelch_on` are all 0.
- R10: With `quiet_level` = 0 no sample is quiet, so squelch never engages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Two's-complement input sample |
| quiet_level | input | 8 | Magnitude below which a sample is quiet |
| gate_en | input | 1 | High in processing modes, low in bypass |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Gated sample |
| squelch_on | output | 1 | Squelch active |

## Verification
The bench targets the window edge first. It sends HOLD_COUNT-1 quiet samples and then a loud one, and it also sends exactly HOLD_COUNT quiet samples. A design that is off by one here mutes one sample early or one sample late. It also targets the comparison boundaries: a magnitude equal to the level, -32768 against the top level 0xFF, and a level of zero. A design with the wrong sign handling or a `<=` comparison would treat these samples as quiet. Other cases check that a loud sample releases squelch on its own output rather than one sample later, that invalid gaps in a run are transparent, and that a very long silence does not wrap the counter back to pass.

// File: rtl/sq_pkg.sv
package sq_pkg;
    typedef enum logic [1:0] {
        ST_PASS  = 2'd0,
        ST_COUNT = 2'd1,
        ST_MUTE  = 2'd2
    } sq_state_e;
endpackage

// File: rtl/sq_magnitude.sv
module sq_magnitude #(
    parameter int SAMPLE_W = 16,
    parameter int LEVEL_W  = 8
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [LEVEL_W-1:0]  level,
    output logic                quiet
);
    localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
    localparam logic [SAMPLE_W-1:0] MOST_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};

    logic [SAMPLE_W-1:0] mag;
    logic [SAMPLE_W-1:0] level_ext;

    always_comb begin
        if (sample == MOST_NEG) begin
            mag = MOST_POS;
        end else if (sample[SAMPLE_W-1]) begin
            mag = (~sample) + {{(SAMPLE_W-1){1'b0}}, 1'b1};
        end else begin
            mag = sample;
        end
    end

    assign level_ext = {{(SAMPLE_W-LEVEL_W){1'b0}}, level};
    assign quiet     = (mag < level_ext);
endmodule

// File: rtl/sq_hold_fsm.sv
module sq_hold_fsm
    import sq_pkg::*;
#(
    parameter int HOLD_COUNT = 200
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      step,
    input  logic      enable,
    input  logic      quiet,
    output sq_state_e state_q,
    output sq_state_e state_d
);
    localparam int CNT_W = $clog2(HOLD_COUNT + 1);
    localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOLD_COUNT);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (step) begin
            if (!enable || !quiet) begin
                state_d = ST_PASS;
                cnt_d   = '0;
            end else begin
                unique case (state_q)
                    ST_PASS, ST_COUNT: begin
                        cnt_d   = cnt_q + ONE_C;
                        state_d = ((cnt_q + ONE_C) >= HOLD_C) ? ST_MUTE : ST_COUNT;
                    end
                    ST_MUTE: begin
                        cnt_d   = HOLD_C;
                        state_d = ST_MUTE;
                    end
                    default: begin
                        cnt_d   = '0;
                        state_d = ST_PASS;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PASS;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end
endmodule

// File: rtl/squelch_gate.sv
module squelch_gate
    import sq_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int LEVEL_W    = 8,
    parameter int HOLD_COUNT = 200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [LEVEL_W-1:0]  quiet_level,
    input  logic                gate_en,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic                squelch_on
);
    logic      is_quiet;
    sq_state_e state_q;
    sq_state_e state_d;

    sq_magnitude #(.SAMPLE_W(SAMPLE_W), .LEVEL_W(LEVEL_W)) u_mag (
        .sample (in_sample),
        .level  (quiet_level),
        .quiet  (is_quiet)
    );

    sq_hold_fsm #(.HOLD_COUNT(HOLD_COUNT)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (in_valid),
        .enable  (gate_en),
        .quiet   (is_quiet),
        .state_q (state_q),
        .state_d (state_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sample <= (state_d == ST_MUTE) ? '0 : in_sample;
            end
        end
    end

    assign squelch_on = (state_q == ST_MUTE);
endmodule

// File: rtl/squelch_gate_chk.sv
module squelch_gate_chk #(
    parameter int SAMPLE_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_sample,
    input logic                gate_en,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_sample,
    input logic                squelch_on
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_sample)));
    // R4
    muted_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (squelch_on && out_valid) |-> (out_sample == '0));
    // R6
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(squelch_on));
    // R7
    bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !gate_en) |=> (!squelch_on && out_sample == $past(in_sample)));
endmodule

bind squelch_gate squelch_gate_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .gate_en    (gate_en),
    .out_valid  (out_valid),
    .out_sample (out_sample),
    .squelch_on (squelch_on)
);

// File: tb/squelch_gate_bench.sv
`timescale 1ns/1ps
module squelch_gate_bench;
    localparam int HOLD = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic [7:0]  quiet_level = 8'h1F;
    logic        gate_en = 1'b1;
    logic        out_valid;
    logic [15:0] out_sample;
    logic        squelch_on;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R9";

    // reference model state
    int    run = 0;
    bit    exp_sq = 0;
    bit    exp_v = 0;
    int    exp_s = 0;
    string exp_tag = "R9";

    squelch_gate #(.HOLD_COUNT(HOLD)) u_squelch_gate (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .quiet_level(quiet_level), .gate_en(gate_en), .out_valid(out_valid),
        .out_sample(out_sample), .squelch_on(squelch_on)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            run = 0; exp_sq = 0; exp_v = 0; exp_s = 0;
        end else begin
            exp_v = in_valid;
            exp_tag = cur_req;
            if (in_valid) begin
                int s;
                int m;
                s = $signed(in_sample);
                m = (s < 0) ? -s : s;
                if (m > 32767) m = 32767;
                if (!gate_en || m >= int'(quiet_level)) begin
                    run = 0; exp_sq = 0; exp_s = in_sample;
                end else begin
                    run = (run + 1 > HOLD) ? HOLD : run + 1;
                    exp_sq = (run >= HOLD);
                    exp_s = exp_sq ? 0 : int'(in_sample);
                end
            end
        end
    end

    // every-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(out_valid == exp_v, {exp_tag, " out_valid"}, out_valid, exp_v);
            check(squelch_on == exp_sq, {exp_tag, " squelch_on"}, squelch_on, exp_sq);
            if (exp_v)
                check(int'(out_sample) == exp_s, {exp_tag, " out_sample"}, out_sample, exp_s);
        end
    end

    task automatic send(input logic [15:0] s);
        @(negedge clk);
        in_valid = 1'b1; in_sample = s;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_n(input int n, input logic [15:0] s);
        for (int i = 0; i < n; i++) send(s);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R9 reset state
        check(out_valid == 0 && out_sample == 0 && squelch_on == 0, "R9 reset", squelch_on, 0);
        @(negedge clk); rst_n = 1'b1;

        cur_req = "R1";
        send(16'h1234); send(16'h8000); send(16'h0040);

        cur_req = "R5";
        send_n(HOLD - 1, 16'h0005);
        #1 check(squelch_on == 0, "R5 before window", squelch_on, 0);
        send(16'h0100);

        cur_req = "R3";
        send_n(HOLD - 1, 16'hFFFB);
        check(squelch_on == 0, "R3 one short", squelch_on, 0);
        send(16'hFFF0);
        check(squelch_on == 1 && out_sample == 0, "R3 window edge", squelch_on, 1);

        cur_req = "R8";
        send_n(HOLD + 60, 16'h0003);
        check(squelch_on == 1, "R8 long silence", squelch_on, 1);

        cur_req = "R5";
        send(16'h001F);
        check(squelch_on == 0 && out_sample == 16'h001F, "R5 release", out_sample, 16'h001F);

        cur_req = "R2";
        send(16'hFFE1); // -31 equals level: loud
        check(out_sample == 16'hFFE1, "R2 equal is loud", out_sample, 16'hFFE1);
        quiet_level = 8'hFF;
        send_n(HOLD - 2, 16'hFF01); // -255: loud
        send_n(HOLD - 1, 16'h00FE);
        send(16'h8000); // saturated magnitude: loud
        check(squelch_on == 0 && out_sample == 16'h8000, "R2 most negative", out_sample, 16'h8000);

        cur_req = "R6";
        for (int i = 0; i < HOLD; i++) begin
            send(16'h0001);
            repeat (i % 3) @(negedge clk);
        end
        check(squelch_on == 1, "R6 gaps", squelch_on, 1);

        cur_req = "R7";
        gate_en = 1'b0;
        send_n(HOLD + 5, 16'h0002);
        check(squelch_on == 0 && out_sample == 16'h0002, "R7 bypass", out_sample, 2);
        gate_en = 1'b1;

        cur_req = "R10";
        quiet_level = 8'h00;
        send_n(HOLD + 5, 16'h0000);
        check(squelch_on == 0, "R10 zero level", squelch_on, 0);

        cur_req = "R4";
        quiet_level = 8'h1F;
        send_n(HOLD + 3, 16'hFFFF);
        check(out_sample == 0, "R4 muted output", out_sample, 0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule